// File: doc/BRIEF.md
# Load Address and Extension Unit

This block performs the address side and the data side of a single register load. From a base register value and an offset it forms the effective address under one of three indexing modes. It also produces the updated base value together with a strobe that tells the register file to write it back. The offset is a zero-extended immediate, an index register value, or an index register value shifted left. After the read returns, the block picks the addressed byte, halfword or word out of the 32-bit memory word. It orders the bytes according to the configured byte order and widens the result to a full 32-bit register value with zeros or with copies of the sign bit.

Requests are accepted on any cycle and flow through a two-stage pipeline, so back-to-back loads are supported. A simple synchronous read port connects the block to memory. On that port, lane b of the data word (bits 8b+7:8b) always carries the byte at word address + b, whatever the byte order. The byte order is a strap captured while reset is held. It is fixed for the rest of the run.

Top module: `ldx_unit`

## Requirements
- R1: A request presented with req_valid high at a rising edge raises mem_req in the next cycle, with mem_addr equal to the effective address with its two low bits cleared. The memory returns that word on mem_rdata one cycle after mem_req. rsp_valid is high for exactly one cycle, two cycles after the request, and requests may arrive on consecutive cycles.
- R2: The offset source is set by req_off_sel: 0 selects req_imm zero-extended to 32 bits, 1 selects req_index, and 2 or 3 select req_index shifted left by req_shamt.
- R3: With req_sub at 0 the offset is added to req_base, and with req_sub at 1 it is subtracted, modulo 2^32.
- R4: req_mode 0 (offset) and 3 address memory at base plus or minus offset. Mode 1 (pre-indexed) addresses memory at that same value. Mode 2 (post-indexed) addresses memory at the unmodified base. rsp_addr reports the effective address.
- R5: wb_en is high only in the response cycle of a mode 1 or mode 2 request, and then wb_value equals base plus or minus offset. It stays low for modes 0 and 3.
- R6: req_size 0 loads the byte in lane addr[1:0] into bits 7:0. With req_signed 0 bits 31:8 are cleared, and with req_signed 1 they copy bit 7.
- R7: req_size 1 loads the two bytes at offsets 2*addr[1] and 2*addr[1]+1, and addr[0] is ignored. In little-endian order the lower-addressed byte lands in bits 7:0, and in big-endian order it lands in bits 15:8. Bits 31:16 are cleared, or copy bit 15 when req_signed is 1.
- R8: req_size 2 or 3 loads the whole word, and addr[1:0] is ignored. Little-endian order puts lane 0 in bits 7:0, and big-endian order puts lane 0 in bits 31:24.
- R9: big_end_pin (1 = big endian) is sampled on every clock while rst_n is low. The value held on the last reset cycle governs until the next reset, and changes on the pin while rst_n is high have no effect.
- R10: While rst_n is low, at the first edge after it is released, and until the first request arrives, mem_req, rsp_valid and wb_en are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| big_end_pin | input | 1 | Byte-order strap, 1 = big endian, captured during reset |
| req_valid | input | 1 | Load request strobe |
| req_mode | input | 2 | Indexing mode: 0 offset, 1 pre-indexed, 2 post-indexed, 3 as offset |
| req_sub | input | 1 | 1 = subtract offset from base |
| req_off_sel | input | 2 | Offset source: 0 immediate, 1 index, 2/3 shifted index |
| req_imm | input | IMM_W | Immediate offset |
| req_base | input | 32 | Base register value |
| req_index | input | 32 | Index register value |
| req_shamt | input | SH_W | Left-shift amount for the index |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_signed | input | 1 | 1 = sign-extend sub-word results |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_req |
| rsp_valid | output | 1 | Load result valid |
| rsp_addr | output | 32 | Effective address of the completing load |
| rsp_data | output | 32 | Extended load result |
| wb_en | output | 1 | Base writeback strobe |
| wb_value | output | 32 | Updated base value |

## Verification
The bench aims at the indexing modes in both directions, including subtraction that wraps below zero and the widest shift. A design that mixes up pre- and post-indexing would show the updated base on rsp_addr, or write back the original base. Sub-word loads with the top bit set, and halfwords at an odd address, expose extension faults and any use of addr[0] as garbage in the upper bits or a shifted halfword. The strap is toggled both inside reset and after it. A design that keeps sampling the pin would reorder halfwords and words in mid-run, and one that latches it too early would use the wrong order after reset.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
   localparam int XLEN   = 32;
   localparam int LANES  = XLEN / 8;
   localparam int LANE_W = $clog2(LANES);

   typedef enum logic [1:0] {
      AM_OFFSET = 2'd0,
      AM_PRE    = 2'd1,
      AM_POST   = 2'd2,
      AM_RSVD   = 2'd3
   } amode_e;

   typedef enum logic [1:0] {
      OS_IMM  = 2'd0,
      OS_REG  = 2'd1,
      OS_SHL  = 2'd2,
      OS_SHL3 = 2'd3
   } osel_e;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_WORD3 = 2'd3
   } lsize_e;
endpackage

// File: rtl/ldx_offset_gen.sv
module ldx_offset_gen
   import ldx_pkg::*;
#(
   parameter int IMM_W      = 12,
   parameter int SH_W       = 5,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  logic [1:0]      sel,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0] idx,
   input  logic [SH_W-1:0] shamt,
   output logic [XLEN-1:0] off
);
   logic [XLEN-1:0] imm_x;

   generate
      if (IMM_SIGNED) begin : g_simm
         assign imm_x = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_uimm
         assign imm_x = {{(XLEN-IMM_W){1'b0}}, imm};
      end
   endgenerate

   always_comb begin
      case (osel_e'(sel))
         OS_IMM:  off = imm_x;
         OS_REG:  off = idx;
         default: off = idx << shamt;
      endcase
   end
endmodule

// File: rtl/ldx_addr_calc.sv
module ldx_addr_calc
   import ldx_pkg::*;
(
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] off,
   input  logic            sub,
   input  logic [1:0]      mode,
   output logic [XLEN-1:0] ea,
   output logic [XLEN-1:0] wbv,
   output logic            wb_req
);
   logic [XLEN-1:0] moved;

   assign moved = sub ? (base - off) : (base + off);
   assign wbv   = moved;

   always_comb begin
      case (amode_e'(mode))
         AM_PRE: begin
            ea     = moved;
            wb_req = 1'b1;
         end
         AM_POST: begin
            ea     = base;
            wb_req = 1'b1;
         end
         default: begin
            ea     = moved;
            wb_req = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/ldx_lane_ext.sv
module ldx_lane_ext
   import ldx_pkg::*;
(
   input  logic [XLEN-1:0]   word,
   input  logic [LANE_W-1:0] lane,
   input  logic [1:0]        size,
   input  logic              sgn,
   input  logic              big,
   output logic [XLEN-1:0]   data
);
   logic [7:0]        ob [LANES];
   logic [7:0]        b8;
   logic [15:0]       h16;
   logic [XLEN-1:0]   w32;
   logic [LANE_W-1:0] h_lo, h_hi;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign ob[b] = word[8*b +: 8];
   end

   assign h_lo = {lane[LANE_W-1:1], 1'b0};
   assign h_hi = {lane[LANE_W-1:1], 1'b1};

   always_comb begin
      b8  = ob[lane];
      h16 = big ? {ob[h_lo], ob[h_hi]} : {ob[h_hi], ob[h_lo]};
      for (int i = 0; i < LANES; i++) begin
         if (big) w32[8*(LANES-1-i) +: 8] = ob[i];
         else     w32[8*i +: 8]           = ob[i];
      end
      case (lsize_e'(size))
         SZ_BYTE: data = {{(XLEN-8){sgn & b8[7]}}, b8};
         SZ_HALF: data = {{(XLEN-16){sgn & h16[15]}}, h16};
         default: data = w32;
      endcase
   end
endmodule

// File: rtl/ldx_unit.sv
module ldx_unit
   import ldx_pkg::*;
#(
   parameter int IMM_W      = 12,
   parameter int SH_W       = 5,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_end_pin,
   input  logic              req_valid,
   input  logic [1:0]        req_mode,
   input  logic              req_sub,
   input  logic [1:0]        req_off_sel,
   input  logic [IMM_W-1:0]  req_imm,
   input  logic [31:0]       req_base,
   input  logic [31:0]       req_index,
   input  logic [SH_W-1:0]   req_shamt,
   input  logic [1:0]        req_size,
   input  logic              req_signed,
   output logic              mem_req,
   output logic [31:0]       mem_addr,
   input  logic [31:0]       mem_rdata,
   output logic              rsp_valid,
   output logic [31:0]       rsp_addr,
   output logic [31:0]       rsp_data,
   output logic              wb_en,
   output logic [31:0]       wb_value
);
   generate
      if (IMM_W < 1 || IMM_W >= XLEN) begin : g_bad_imm
         $error("ldx_unit: IMM_W out of range");
      end
      if (SH_W < 1 || SH_W > $clog2(XLEN)) begin : g_bad_sh
         $error("ldx_unit: SH_W out of range");
      end
   endgenerate

   logic [XLEN-1:0] off, ea_c, wbv_c;
   logic            wbreq_c;
   logic            big_q;

   logic            s1_valid, s2_valid;
   logic [XLEN-1:0] s1_ea, s2_ea, s1_wbv, s2_wbv;
   logic            s1_wb, s2_wb, s1_sgn, s2_sgn;
   logic [1:0]      s1_size, s2_size;

   ldx_offset_gen #(.IMM_W(IMM_W), .SH_W(SH_W), .IMM_SIGNED(IMM_SIGNED)) u_off (
      .sel(req_off_sel), .imm(req_imm), .idx(req_index), .shamt(req_shamt), .off(off)
   );

   ldx_addr_calc u_addr (
      .base(req_base), .off(off), .sub(req_sub), .mode(req_mode),
      .ea(ea_c), .wbv(wbv_c), .wb_req(wbreq_c)
   );

   // byte-order strap: follows the pin only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) big_q <= big_end_pin;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s2_valid <= 1'b0;
      end else begin
         s1_valid <= req_valid;
         s2_valid <= s1_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (req_valid) begin
         s1_ea   <= ea_c;
         s1_wbv  <= wbv_c;
         s1_wb   <= wbreq_c;
         s1_size <= req_size;
         s1_sgn  <= req_signed;
      end
      if (s1_valid) begin
         s2_ea   <= s1_ea;
         s2_wbv  <= s1_wbv;
         s2_wb   <= s1_wb;
         s2_size <= s1_size;
         s2_sgn  <= s1_sgn;
      end
   end

   assign mem_req  = s1_valid;
   assign mem_addr = {s1_ea[XLEN-1:LANE_W], {LANE_W{1'b0}}};

   ldx_lane_ext u_ext (
      .word(mem_rdata), .lane(s2_ea[LANE_W-1:0]), .size(s2_size),
      .sgn(s2_sgn), .big(big_q), .data(rsp_data)
   );

   assign rsp_valid = s2_valid;
   assign rsp_addr  = s2_ea;
   assign wb_en     = s2_valid & s2_wb;
   assign wb_value  = s2_wbv;
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [1:0]  req_mode,
   input logic [31:0] req_base,
   input logic [1:0]  req_size,
   input logic        req_signed,
   input logic        mem_req,
   input logic        rsp_valid,
   input logic [31:0] rsp_addr,
   input logic [31:0] rsp_data,
   input logic        wb_en,
   input logic        order_big
);
   a_r1_mem_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(req_valid) |-> mem_req);

   a_r1_rsp_after_two: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n, 2) && $past(rst_n) && $past(req_valid, 2) |-> rsp_valid);

   a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid, 2));

   a_r5_wb_inside_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> rsp_valid);

   a_r5_wb_mode: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (wb_en == ($past(req_mode, 2) == 2'd1 || $past(req_mode, 2) == 2'd2)));

   a_r4_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_mode, 2) == 2'd2 |-> rsp_addr == $past(req_base, 2));

   a_r6_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_size, 2) == 2'd0 && !$past(req_signed, 2) |-> rsp_data[31:8] == 24'd0);

   a_r6_byte_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_size, 2) == 2'd0 && $past(req_signed, 2) |-> rsp_data[31:8] == {24{rsp_data[7]}});

   a_r7_half_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && $past(req_size, 2) == 2'd1 && $past(req_signed, 2) |-> rsp_data[31:16] == {16{rsp_data[15]}});

   a_r9_order_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(order_big));
endmodule

bind ldx_unit ldx_unit_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
   .req_base(req_base), .req_size(req_size), .req_signed(req_signed),
   .mem_req(mem_req), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
   .rsp_data(rsp_data), .wb_en(wb_en), .order_big(big_q)
);

// File: tb/ldx_unit_bench.sv
`timescale 1ns/1ps
module ldx_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        big_end_pin = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_mode = '0;
   logic        req_sub = 1'b0;
   logic [1:0]  req_off_sel = '0;
   logic [11:0] req_imm = '0;
   logic [31:0] req_base = '0;
   logic [31:0] req_index = '0;
   logic [4:0]  req_shamt = '0;
   logic [1:0]  req_size = '0;
   logic        req_signed = 1'b0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_addr, rsp_data;
   logic        wb_en;
   logic [31:0] wb_value;

   always #5 clk = ~clk;

   ldx_unit u_ldx_unit (
      .clk(clk), .rst_n(rst_n), .big_end_pin(big_end_pin), .req_valid(req_valid),
      .req_mode(req_mode), .req_sub(req_sub), .req_off_sel(req_off_sel),
      .req_imm(req_imm), .req_base(req_base), .req_index(req_index),
      .req_shamt(req_shamt), .req_size(req_size), .req_signed(req_signed),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
      .wb_en(wb_en), .wb_value(wb_value)
   );

   typedef struct {
      int          due;
      logic [31:0] addr;
      logic [31:0] data;
      logic [31:0] wbv;
      logic        wben;
      int          size;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_run = 0;
   int   n_fail = 0;
   logic rst_seen = 1'b0;
   logic tb_big = 1'b0;
   logic finished = 1'b0;
   int unsigned seed = 32'h1234_5678;

   always @(posedge clk) begin
      cyc      <= cyc + 1;
      rst_seen <= rst_n;
   end

   function automatic logic [31:0] memw(input logic [31:0] a);
      return (a >> 2) * 32'h9E37_79B1 ^ 32'h7F80_13C5;
   endfunction

   // memory model: lane b holds the byte at word address + b
   always @(posedge clk) if (mem_req) mem_rdata <= memw(mem_addr);

   function automatic logic [7:0] mbyte(input logic [31:0] a);
      logic [31:0] w;
      w = memw({a[31:2], 2'b00});
      return w[8*a[1:0] +: 8];
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      bit mem_exp;
      mem_exp = 0;
      if (!rst_seen) begin
         chk("R10", "mem_req in reset", {31'd0, mem_req}, 32'd0);
         chk("R10", "rsp_valid in reset", {31'd0, rsp_valid}, 32'd0);
         chk("R10", "wb_en in reset", {31'd0, wb_en}, 32'd0);
         return;
      end
      foreach (q[i]) if (q[i].due == cyc + 1) begin
         mem_exp = 1;
         chk("R1", "mem_addr", mem_addr, {q[i].addr[31:2], 2'b00});
      end
      chk("R1", "mem_req", {31'd0, mem_req}, {31'd0, mem_exp});
      if (q.size() > 0 && q[0].due == cyc) begin
         chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
         chk("R4", "rsp_addr", rsp_addr, q[0].addr);
         chk("R5", "wb_en", {31'd0, wb_en}, {31'd0, q[0].wben});
         if (q[0].wben) chk("R5", "wb_value", wb_value, q[0].wbv);
         case (q[0].size)
            0:       chk("R6", "byte data", rsp_data, q[0].data);
            1:       chk("R7", "half data", rsp_data, q[0].data);
            default: chk("R8", "word data", rsp_data, q[0].data);
         endcase
         void'(q.pop_front());
      end else begin
         chk("R1", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
         chk("R5", "idle wb_en", {31'd0, wb_en}, 32'd0);
      end
   endtask

   task automatic step();
      @(negedge clk);
      check_outputs();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         step();
         req_valid = 1'b0;
      end
   endtask

   task automatic issue(input logic [1:0] mode, input logic sub, input logic [1:0] sel,
                        input logic [11:0] imm, input logic [31:0] base, input logic [31:0] idx,
                        input logic [4:0] sh, input logic [1:0] size, input logic sgn);
      exp_t e;
      logic [31:0] off, moved, lo;
      logic [7:0]  x0, x1;
      step();
      req_valid = 1'b1; req_mode = mode; req_sub = sub; req_off_sel = sel;
      req_imm = imm; req_base = base; req_index = idx; req_shamt = sh;
      req_size = size; req_signed = sgn;
      // R2 offset source, R3 direction
      if (sel == 2'd0)      off = {20'd0, imm};
      else if (sel == 2'd1) off = idx;
      else                  off = idx << sh;
      moved  = sub ? base - off : base + off;
      e.due  = cyc + 2;
      e.addr = (mode == 2'd2) ? base : moved;
      e.wbv  = moved;
      e.wben = (mode == 2'd1 || mode == 2'd2);
      e.size = (size == 2'd3) ? 2 : int'(size);
      if (size == 2'd0) begin
         x0 = mbyte(e.addr);
         e.data = {{24{sgn & x0[7]}}, x0};
      end else if (size == 2'd1) begin
         lo = {e.addr[31:1], 1'b0};
         x0 = mbyte(lo); x1 = mbyte(lo + 1);
         e.data[15:0] = tb_big ? {x0, x1} : {x1, x0};
         e.data[31:16] = {16{sgn & e.data[15]}};
      end else begin
         lo = {e.addr[31:2], 2'b00};
         for (int i = 0; i < 4; i++) begin
            if (tb_big) e.data[8*(3-i) +: 8] = mbyte(lo + i);
            else        e.data[8*i +: 8]     = mbyte(lo + i);
         end
      end
      q.push_back(e);
   endtask

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1664525 + 32'd1013904223;
      return seed;
   endfunction

   task automatic random_burst(input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] r1, r2, r3;
         r1 = rnd(); r2 = rnd(); r3 = rnd();
         issue(r1[1:0], r1[2], r1[4:3], r2[11:0], rnd(), {20'd0, r3[11:0]},
               r1[9:5], r1[11:10], r1[12]);
         if (r1[15:13] == 3'd0) idle(1);
      end
      idle(3);
   endtask

   task automatic do_reset(input logic fin);
      step();
      rst_n = 1'b0; req_valid = 1'b0; big_end_pin = ~fin;
      idle(3);
      big_end_pin = fin;          // last value seen in reset wins (R9)
      idle(2);
      rst_n = 1'b1;
      tb_big = fin;
      q.delete();
      idle(2);                    // R10: nothing comes out after release
   endtask

   initial begin
      do_reset(1'b0);
      // directed: R4 offset / pre / post with R3 subtract wrap
      issue(2'd0, 1'b0, 2'd0, 12'hFFF, 32'h0000_1000, 32'd0, 5'd0, 2'd2, 1'b0);
      issue(2'd1, 1'b1, 2'd1, 12'd0, 32'h0000_0004, 32'h0000_0010, 5'd0, 2'd2, 1'b0);
      issue(2'd2, 1'b0, 2'd2, 12'd0, 32'h0000_2003, 32'h0000_0001, 5'd31, 2'd0, 1'b1);
      issue(2'd3, 1'b0, 2'd3, 12'd0, 32'h0000_0100, 32'h0000_0003, 5'd4, 2'd1, 1'b0);
      // R6/R7 sign extension, odd halfword address, word at offset 1
      for (int b = 0; b < 4; b++) issue(2'd0, 1'b0, 2'd0, 12'(b), 32'h0000_0040, 32'd0, 5'd0, 2'd0, 1'b1);
      for (int b = 0; b < 4; b++) issue(2'd0, 1'b0, 2'd0, 12'(b), 32'h0000_0040, 32'd0, 5'd0, 2'd1, 1'b1);
      issue(2'd0, 1'b0, 2'd0, 12'd1, 32'h0000_0080, 32'd0, 5'd0, 2'd3, 1'b0);
      idle(3);
      random_burst(150);
      // R9: pin moves after reset, order must stay little endian
      big_end_pin = 1'b1;
      idle(2);
      for (int b = 0; b < 4; b++) issue(2'd1, 1'b0, 2'd0, 12'(b), 32'h0000_0300, 32'd0, 5'd0, 2'(b % 3), 1'b0);
      idle(3);
      random_burst(60);
      // big-endian run; pin toggles inside reset
      do_reset(1'b1);
      for (int b = 0; b < 4; b++) issue(2'd0, 1'b0, 2'd0, 12'(b), 32'h0000_0500, 32'd0, 5'd0, 2'd1, 1'b1);
      issue(2'd2, 1'b1, 2'd0, 12'd8, 32'h0000_0502, 32'd0, 5'd0, 2'd2, 1'b0);
      idle(2);
      big_end_pin = 1'b0;
      random_burst(150);
      idle(4);
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule